// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block keeps wall-clock time and date as binary-coded decimal values in a small byte-wide register file. A free-running base tick enable is divided by a programmable prescaler into one-second events. Each event advances seconds, and the carry ripples through minutes, hours, day of month, weekday, month and year. Month lengths and leap Februaries follow the calendar for the years 2000 to 2099. Two-digit years are stored, so year 00 means 2000.

Software reaches the block through a simple register bus: an address, write data with a write strobe, and a read strobe whose data appears one cycle later. A control byte holds a stop bit and a stored load-capacitance select. One byte is free scratch storage. Bit 7 of the seconds byte flags that the oscillator stopped or power was lost. While a multi-byte transfer is in progress, the burst-active input freezes the visible time. A second that elapses during the transfer is held back and applied when the transfer ends. The current time fields are brought out as ports so that an alarm comparator can watch them.

Top module: `rtc_calendar_core`

## Requirements
- R1: Reset sets the time to 2000-01-01 00:00:00 with weekday 6 and sets the oscillator-stop flag. The control byte and the scratch byte both read 0x00.
- R2: The register map is as follows. Address 0x00 is control, 0x03 is scratch, and 0x04 to 0x0A hold seconds, minutes, hours, day, weekday, month and year in that order. Field masks are 7, 7, 6, 6, 3, 5 and 8 bits, so writing 0xFF to hours reads back 0x3F. Unmapped addresses (0x01, 0x02, 0x0B to 0x0F) ignore writes and read 0x00. A read's data appears on the cycle after the read strobe and holds until the next read strobe.
- R3: With the block running, seconds advance exactly once every TICKS_PER_SEC base ticks.
- R4: Seconds and minutes count 00 to 59 in BCD, and hours count 00 to 23. Each wrap carries into the next field.
- R5: The day wraps to 01 after the last day of the month. Months have 30 days for 4, 6, 9 and 11, and 31 days otherwise, except February. February has 29 days when the two-digit year is divisible by 4 and 28 days otherwise. The weekday advances modulo 7. Month 12 wraps to 01, and year 99 wraps to 00.
- R6: While bit 5 of the control byte is 1, the time does not advance and the prescaler is held cleared. After the bit is cleared, the first advance comes a full TICKS_PER_SEC base ticks later.
- R7: A write to any time register takes effect on the next cycle. It also clears the prescaler phase, so the next advance is a full TICKS_PER_SEC base ticks later.
- R8: While burst-active is high, the time outputs do not change. At most one elapsed second is remembered, and it is applied in the first cycle after burst-active falls.
- R9: The oscillator-stop input sets bit 7 of the seconds byte. Software clears the bit by writing 0 there, and the seconds value itself is not disturbed when the flag sets.
- R10: Bit 0 of the control byte and the scratch byte store and return whatever was written. Bits 1 to 4, 6 and 7 of the control byte read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Prescaler input enable, one pulse per base period |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, valid the cycle after rdEn |
| burstActive | input | 1 | High during a multi-byte transfer; freezes the time |
| oscFail | input | 1 | Sets the oscillator-stop flag |
| secOut | output | 7 | Current seconds, BCD |
| minOut | output | 7 | Current minutes, BCD |
| hourOut | output | 6 | Current hours, BCD |
| dayOut | output | 6 | Current day of month, BCD |
| wdayOut | output | 3 | Current weekday, binary 0 to 6 |
| monOut | output | 5 | Current month, BCD |
| yearOut | output | 8 | Current two-digit year, BCD |

## Verification
A wrong prescaler phase shows at the time outputs within one second as an advance that comes early or late by a base tick. For that reason, each second boundary is checked one tick before and at the expected tick. A corrupted carry or month-length decision stays hidden until the affected field wraps. The bench therefore places the date on the last second of every month across several years, and on 28 February for all hundred years, and looks one second later. A lost or doubled deferred tick appears on the first cycle after the burst ends, and again one second later.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // register indices; the time fields must stay consecutive in this order
  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_RAM  = 8'h03;
  localparam logic [7:0] ADDR_SEC  = 8'h04;
  localparam logic [7:0] ADDR_MIN  = 8'h05;
  localparam logic [7:0] ADDR_HOUR = 8'h06;
  localparam logic [7:0] ADDR_DAY  = 8'h07;
  localparam logic [7:0] ADDR_WDAY = 8'h08;
  localparam logic [7:0] ADDR_MON  = 8'h09;
  localparam logic [7:0] ADDR_YEAR = 8'h0A;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;    // apply one second
    logic timeWrite;  // bus write hits a time register
  } calStrobes_t;

  // next BCD value, no wrap handling
  function automatic logic [7:0] bcdStep(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic isLeapBcd(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] lastDayBcd(input logic [7:0] mon, input logic [7:0] y);
    case (mon)
      8'h02:                      return isLeapBcd(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic              burstActive,
  input  logic              stopBit,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output calStrobes_t       strobes
);

  localparam int unsigned PRESC_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(TICKS_PER_SEC - 1);

  logic [PRESC_W-1:0] presc;
  logic               pending;
  logic [7:0]         regIdx;
  logic               timeHit;
  logic               hold;
  logic               secondEvt;

  assign regIdx    = 8'(addr);
  assign timeHit   = wrEn && (regIdx >= ADDR_SEC) && (regIdx <= ADDR_YEAR);
  assign hold      = stopBit || timeHit;
  assign secondEvt = baseTick && (presc == PRESC_LAST) && !hold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc   <= '0;
      pending <= 1'b0;
    end else begin
      if (hold)          presc <= '0;
      else if (baseTick) presc <= (presc == PRESC_LAST) ? '0 : presc + 1'b1;

      // one remembered second; a fresh second on the release cycle queues one more
      if (hold)             pending <= 1'b0;
      else if (burstActive) pending <= pending || secondEvt;
      else                  pending <= pending && secondEvt;
    end
  end

  always_comb begin
    strobes.timeWrite = timeHit;
    strobes.advance   = !burstActive && !hold && (pending || secondEvt);
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobes_t       strobes,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              oscFail,
  output logic [7:0]        rdData,
  output logic              stopBit,
  output logic [6:0]        secQ,
  output logic [6:0]        minQ,
  output logic [5:0]        hourQ,
  output logic [5:0]        dayQ,
  output logic [2:0]        wdayQ,
  output logic [4:0]        monQ,
  output logic [7:0]        yearQ
);

  logic [7:0] regIdx;
  logic       capSel;
  logic       osFlag;
  logic [7:0] ramQ;
  logic       secEnd, minEnd, hourEnd, dayEnd, monEnd;
  logic       carryMin, carryHour, carryDay, carryMon, carryYear;
  logic [6:0] secNext, minNext;
  logic [5:0] hourNext, dayNext;
  logic [2:0] wdayNext;
  logic [4:0] monNext;
  logic [7:0] yearNext;
  logic [7:0] readVal;

  assign regIdx = 8'(addr);

  always_comb begin
    secEnd   = (secQ == 7'h59);
    minEnd   = (minQ == 7'h59);
    hourEnd  = (hourQ == 6'h23);
    dayEnd   = ({2'b00, dayQ} == lastDayBcd({3'b000, monQ}, yearQ));
    monEnd   = (monQ == 5'h12);

    carryMin  = secEnd;
    carryHour = carryMin && minEnd;
    carryDay  = carryHour && hourEnd;
    carryMon  = carryDay && dayEnd;
    carryYear = carryMon && monEnd;

    secNext  = secEnd  ? 7'h00 : 7'(bcdStep({1'b0, secQ}));
    minNext  = minEnd  ? 7'h00 : 7'(bcdStep({1'b0, minQ}));
    hourNext = hourEnd ? 6'h00 : 6'(bcdStep({2'b00, hourQ}));
    dayNext  = dayEnd  ? 6'h01 : 6'(bcdStep({2'b00, dayQ}));
    wdayNext = (wdayQ >= 3'd6) ? 3'd0 : wdayQ + 3'd1;
    monNext  = monEnd  ? 5'h01 : 5'(bcdStep({3'b000, monQ}));
    yearNext = (yearQ == 8'h99) ? 8'h00 : bcdStep(yearQ);
  end

  always_comb begin
    case (regIdx)
      ADDR_CTRL: readVal = {2'b00, stopBit, 4'b0000, capSel};
      ADDR_RAM:  readVal = ramQ;
      ADDR_SEC:  readVal = {osFlag, secQ};
      ADDR_MIN:  readVal = {1'b0, minQ};
      ADDR_HOUR: readVal = {2'b00, hourQ};
      ADDR_DAY:  readVal = {2'b00, dayQ};
      ADDR_WDAY: readVal = {5'b00000, wdayQ};
      ADDR_MON:  readVal = {3'b000, monQ};
      ADDR_YEAR: readVal = yearQ;
      default:   readVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ    <= 7'h00;
      minQ    <= 7'h00;
      hourQ   <= 6'h00;
      dayQ    <= 6'h01;
      wdayQ   <= 3'd6;
      monQ    <= 5'h01;
      yearQ   <= 8'h00;
      osFlag  <= 1'b1;
      stopBit <= 1'b0;
      capSel  <= 1'b0;
      ramQ    <= 8'h00;
      rdData  <= 8'h00;
    end else begin
      if (strobes.timeWrite) begin
        case (regIdx)
          ADDR_SEC:  secQ  <= wrData[6:0];
          ADDR_MIN:  minQ  <= wrData[6:0];
          ADDR_HOUR: hourQ <= wrData[5:0];
          ADDR_DAY:  dayQ  <= wrData[5:0];
          ADDR_WDAY: wdayQ <= wrData[2:0];
          ADDR_MON:  monQ  <= wrData[4:0];
          default:   yearQ <= wrData;
        endcase
      end else if (strobes.advance) begin
        secQ <= secNext;
        if (carryMin)  minQ  <= minNext;
        if (carryHour) hourQ <= hourNext;
        if (carryDay) begin
          dayQ  <= dayNext;
          wdayQ <= wdayNext;
        end
        if (carryMon)  monQ  <= monNext;
        if (carryYear) yearQ <= yearNext;
      end

      if (oscFail)                                        osFlag <= 1'b1;
      else if (strobes.timeWrite && regIdx == ADDR_SEC)   osFlag <= wrData[7];

      if (wrEn && regIdx == ADDR_CTRL) begin
        stopBit <= wrData[5];
        capSel  <= wrData[0];
      end
      if (wrEn && regIdx == ADDR_RAM) ramQ <= wrData;

      if (rdEn) rdData <= readVal;
    end
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  input  logic              burstActive,
  input  logic              oscFail,
  output logic [6:0]        secOut,
  output logic [6:0]        minOut,
  output logic [5:0]        hourOut,
  output logic [5:0]        dayOut,
  output logic [2:0]        wdayOut,
  output logic [4:0]        monOut,
  output logic [7:0]        yearOut
);

  calStrobes_t strobes;
  logic        stopBit;

  rtc_cal_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .ADDR_W       (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .baseTick   (baseTick),
    .burstActive(burstActive),
    .stopBit    (stopBit),
    .wrEn       (wrEn),
    .addr       (addr),
    .strobes    (strobes)
  );

  rtc_cal_datapath #(
    .ADDR_W(ADDR_W)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .oscFail(oscFail),
    .rdData (rdData),
    .stopBit(stopBit),
    .secQ   (secOut),
    .minQ   (minOut),
    .hourQ  (hourOut),
    .dayQ   (dayOut),
    .wdayQ  (wdayOut),
    .monQ   (monOut),
    .yearQ  (yearOut)
  );

endmodule

// File: rtl/rtc_calendar_core_checks.sv
module rtc_calendar_core_checks (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       burstActive,
  input logic [7:0] rdData,
  input logic       stopBit,
  input logic       advance,
  input logic       timeWrite,
  input logic [6:0] secOut,
  input logic [6:0] minOut,
  input logic [5:0] hourOut,
  input logic [5:0] dayOut,
  input logic [2:0] wdayOut,
  input logic [4:0] monOut,
  input logic [7:0] yearOut
);

  logic [41:0] timeVec;
  assign timeVec = {secOut, minOut, hourOut, dayOut, wdayOut, monOut, yearOut};

  // R8: frozen during a burst unless software writes
  assert_burst_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(burstActive) && !$past(wrEn)) |-> $stable(timeVec));

  // R8: the control never releases a second while the burst is open
  assert_no_advance_in_burst_R8: assert property (@(posedge clk) disable iff (!rstN)
    burstActive |-> !advance);

  // R6: stopped time holds
  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stopBit) && !$past(wrEn)) |-> $stable(timeVec));

  // R7: a time write wins over a second event
  assert_write_over_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeWrite |-> !advance);

  // R2: read data only moves after a read strobe
  assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> $stable(rdData));

endmodule

bind rtc_calendar_core rtc_calendar_core_checks u_checks (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .burstActive(burstActive),
  .rdData     (rdData),
  .stopBit    (stopBit),
  .advance    (strobes.advance),
  .timeWrite  (strobes.timeWrite),
  .secOut     (secOut),
  .minOut     (minOut),
  .hourOut    (hourOut),
  .dayOut     (dayOut),
  .wdayOut    (wdayOut),
  .monOut     (monOut),
  .yearOut    (yearOut)
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;

  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic       burstActive = 1'b0;
  logic       oscFail = 1'b0;
  logic [7:0] rdData;
  logic [6:0] secOut, minOut;
  logic [5:0] hourOut, dayOut;
  logic [2:0] wdayOut;
  logic [4:0] monOut;
  logic [7:0] yearOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  rtc_calendar_core #(.TICKS_PER_SEC(TPS), .ADDR_W(4)) u0 (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .burstActive(burstActive),
    .oscFail(oscFail), .secOut(secOut), .minOut(minOut), .hourOut(hourOut),
    .dayOut(dayOut), .wdayOut(wdayOut), .monOut(monOut), .yearOut(yearOut)
  );

  always #2.5 clk = ~clk;

  function automatic int bcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int daysIn(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 4'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = int'(rdData);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); baseTick = 1'b1;
      @(negedge clk); baseTick = 1'b0;
    end
  endtask

  task automatic setDate(input int y, input int m, input int d, input int wd,
                         input int h, input int mi, input int s);
    wr(10, bcd(y)); wr(9, bcd(m)); wr(7, bcd(d)); wr(8, wd);
    wr(6, bcd(h));  wr(5, bcd(mi)); wr(4, bcd(s));
  endtask

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sec", secOut, 0);   check("R1 min", minOut, 0);
    check("R1 hour", hourOut, 0); check("R1 day", dayOut, 1);
    check("R1 wday", wdayOut, 6); check("R1 mon", monOut, 1);
    check("R1 year", yearOut, 0);
    rd(4, v); check("R1 os flag", v, 8'h80);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(3, v); check("R1 ram", v, 0);

    // R10 scratch and control storage, R2 masks and unmapped addresses
    wr(3, 8'hA5); rd(3, v); check("R10 ram", v, 8'hA5);
    wr(0, 8'hFF); rd(0, v); check("R10 ctrl mask", v, 8'h21);
    wr(0, 8'h01); rd(0, v); check("R10 cap bit", v, 8'h01);
    wr(1, 8'hFF); rd(1, v); check("R2 unmapped 1", v, 0);
    wr(2, 8'hFF); rd(2, v); check("R2 unmapped 2", v, 0);
    rd(15, v); check("R2 unmapped F", v, 0);
    wr(6, 8'hFF); rd(6, v); check("R2 hour mask", v, 8'h3F);
    wr(9, 8'hFF); rd(9, v); check("R2 month mask", v, 8'h1F);
    wr(8, 8'hFF); rd(8, v); check("R2 wday mask", v, 8'h07);
    wr(5, 8'hFF); rd(5, v); check("R2 min mask", v, 8'h7F);
    rd(3, v);
    @(negedge clk); addr = 4'd4;
    @(negedge clk); check("R2 read hold", rdData, 8'hA5);

    // R9 oscillator-stop flag
    wr(4, 8'h00); rd(4, v); check("R9 clear", v, 8'h00);
    wr(4, 8'h15);
    @(negedge clk); oscFail = 1'b1;
    @(negedge clk); oscFail = 1'b0;
    rd(4, v); check("R9 set keeps seconds", v, 8'h95);
    wr(4, 8'h15); rd(4, v); check("R9 cleared by write", v, 8'h15);

    // R3 and R4: second-by-second sweep over two minutes
    setDate(0, 1, 1, 0, 0, 0, 0);
    tick(TPS - 1); check("R3 early", secOut, 0);
    tick(1);       check("R3 on time", secOut, 1);
    for (int s = 2; s <= 130; s++) begin
      tick(TPS);
      check("R3 sec", secOut, bcd(s % 60));
      check("R4 min", minOut, bcd(s / 60));
    end
    setDate(5, 3, 10, 2, 23, 59, 59);
    tick(TPS);
    check("R4 hour wrap", hourOut, 0); check("R4 min wrap", minOut, 0);
    check("R4 sec wrap", secOut, 0);   check("R4 day carry", dayOut, 8'h11);
    check("R5 wday", wdayOut, 3);

    // R5 month ends over several years
    for (int yi = 0; yi < 6; yi++) begin
      int y;
      y = (yi == 5) ? 99 : yi;
      for (int m = 1; m <= 12; m++) begin
        setDate(y, m, daysIn(m, y), 6, 23, 59, 59);
        tick(TPS);
        check("R5 day", dayOut, 1);
        check("R5 month", monOut, bcd(m == 12 ? 1 : m + 1));
        check("R5 year", yearOut, bcd(m == 12 ? (y + 1) % 100 : y));
        check("R5 wday mod 7", wdayOut, 0);
      end
    end
    // R5 February 28 for every year
    for (int y = 0; y < 100; y++) begin
      setDate(y, 2, 28, 1, 23, 59, 59);
      tick(TPS);
      check("R5 leap feb", dayOut, (y % 4 == 0) ? 8'h29 : 8'h01);
    end

    // R6 stop bit
    setDate(10, 6, 15, 3, 12, 0, 16);
    tick(2);
    wr(0, 8'h20);
    tick(3 * TPS);
    check("R6 stopped", secOut, 8'h16);
    rd(0, v); check("R6 ctrl readback", v, 8'h20);
    wr(0, 8'h00);
    tick(TPS - 1); check("R6 fresh phase", secOut, 8'h16);
    tick(1);       check("R6 restart", secOut, 8'h17);

    // R7 write clears prescaler phase
    tick(2);
    wr(4, 8'h30);
    check("R7 immediate", secOut, 8'h30);
    tick(TPS - 1); check("R7 full second", secOut, 8'h30);
    tick(1);       check("R7 advance", secOut, 8'h31);

    // R8 burst freeze with one deferred second
    setDate(10, 6, 15, 3, 12, 0, 20);
    @(negedge clk); burstActive = 1'b1;
    tick(TPS);     check("R8 frozen", secOut, 8'h20);
    tick(TPS);     check("R8 still frozen", secOut, 8'h20);
    rd(4, v);      check("R8 frozen read", v, 8'h20);
    @(negedge clk); burstActive = 1'b0;
    @(negedge clk); check("R8 deferred applied", secOut, 8'h21);
    repeat (3) @(negedge clk);
    check("R8 only one kept", secOut, 8'h21);
    tick(TPS);     check("R8 next second", secOut, 8'h22);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule